// File: doc/BRIEF.md
# Stereo Clickless Volume Ramp with Soft Mute

This block scales a stereo stream of signed samples by a per-channel 14-bit unsigned volume word. The gain is linear: each sample is multiplied by the working volume and divided by 2^14. The working volume does not jump to a new request. Its coarse part, the upper 10 bits, moves one step per sample toward the request. Its fine part, the lower 4 bits, follows the request at once. A full-range coarse change therefore takes 1023 sample periods, which is roughly 21 ms at a 48 kHz rate.

Volume requests are captured on a single-cycle load pulse. They only influence the gain at the next sample strobe after that pulse. A soft mute, asserted by either a mute pin or a mute control bit, makes zero the goal of the same ramp. The gain falls smoothly to zero and climbs back to the held request once mute is released. The left and right channels keep separate ramp state and advance on the shared sample strobe.

Top module: `stereo_gain_ramp`

## Requirements
- R1: While `rst_n` is low, `out_left`, `out_right` and `out_valid` are 0 (midscale), whatever the other inputs do.
- R2: After reset, both working volumes and both held requests are 0.
- R3: On each sample strobe, each output is loaded with floor(x * (g + g[13]) / 16384). Here x is the signed input sample and g is the channel's working volume before that strobe's update.
- R4: On each sample strobe, the upper 10 bits of a working volume move by exactly one toward the upper 10 bits of its goal, or stay put when they are equal.
- R5: On each sample strobe, the lower 4 bits of a working volume take the lower 4 bits of the goal directly.
- R6: `vol_left`/`vol_right` are captured when `vol_load` is high. A capture only affects the gain from the next strobe onward. A load in the same cycle as a strobe does not affect that strobe.
- R7: While `mute_pin` or `mute_bit` is high at a strobe, the goal of both channels is 0, so the gain ramps down to zero.
- R8: After mute is released, the gain ramps back up to the held request.
- R9: Each channel ramps and scales independently of the other channel's request and sample.
- R10: Without a strobe, the working volumes and outputs hold their values, even when the sample and volume inputs change.
- R11: A working volume of all ones (0x3FFF) passes every sample unchanged, including both full-scale extremes.
- R12: `out_valid` is high for exactly the cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe per stereo sample |
| smp_left | input | 24 | Left sample, twos complement |
| smp_right | input | 24 | Right sample, twos complement |
| vol_load | input | 1 | Captures both volume requests |
| vol_left | input | 14 | Left volume request, unsigned, 0x3FFF is unity |
| vol_right | input | 14 | Right volume request, unsigned, 0x3FFF is unity |
| mute_pin | input | 1 | Hardware mute request |
| mute_bit | input | 1 | Control-register mute request |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| out_valid | output | 1 | Outputs updated in the previous cycle |

## Verification
A request latch and a sample strobe can occur in the same cycle. The bench raises `vol_load` together with `smp_valid` and requires that strobe to step toward the old request, with the new one showing only from the next strobe. A mute edge can also coincide with a ramp step. The bench changes the mute inputs between strobes and drives a fixed probe sample of 16384. The output then equals the effective gain directly, so every strobe shows whether the coarse part moved by one in the right direction and whether the fine part went to zero or to the request.

// File: rtl/gr_pkg.sv
// Shared widths and channel indexing for the stereo gain ramp.
// Assumes two channels; widths are the defaults the modules take.
package gr_pkg;
    localparam int SMP_W_D  = 24;
    localparam int VOL_W_D  = 14;
    localparam int FINE_W_D = 4;
    localparam int CH_N     = 2;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } ch_e;
endpackage

// File: rtl/gr_ramp.sv
// Per-channel working volume. Holds the captured request and steps the
// coarse bits one count per strobe toward the goal. The fine bits load
// the goal directly. The goal is zero while mute is asserted.
// Assumes step_en is a single-cycle strobe; load_en may coincide with it.
module gr_ramp #(
    parameter int VOL_W  = gr_pkg::VOL_W_D,
    parameter int FINE_W = gr_pkg::FINE_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             load_en,
    input  logic             mute,
    input  logic [VOL_W-1:0] req_in,
    output logic [VOL_W-1:0] gain
);
    localparam int COARSE_W = VOL_W - FINE_W;

    logic [VOL_W-1:0]    req_q;
    logic [VOL_W-1:0]    goal;
    logic [COARSE_W-1:0] coarse_q;
    logic [COARSE_W-1:0] coarse_goal;
    logic [FINE_W-1:0]   fine_q;

    // Capture the request on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       req_q <= '0;
        else if (load_en) req_q <= req_in;
    end

    // Select the goal: zero when muted, else the held request.
    always_comb begin
        goal        = mute ? '0 : req_q;
        coarse_goal = goal[VOL_W-1:FINE_W];
    end

    // Step coarse bits by one and load fine bits on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            fine_q   <= '0;
        end else if (step_en) begin
            fine_q <= goal[FINE_W-1:0];
            if (coarse_q < coarse_goal)      coarse_q <= coarse_q + 1'b1;
            else if (coarse_q > coarse_goal) coarse_q <= coarse_q - 1'b1;
        end
    end

    assign gain = {coarse_q, fine_q};
endmodule

// File: rtl/gr_scale.sv
// Linear scaler: signed sample times unsigned volume, divided by
// 2^VOL_W and saturated. An all-ones volume is bumped to 2^VOL_W so that
// it is exact unity. The output is registered on en.
// Assumes gain is the pre-update working volume at the strobe edge.
module gr_scale #(
    parameter int SMP_W = gr_pkg::SMP_W_D,
    parameter int VOL_W = gr_pkg::VOL_W_D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [VOL_W-1:0]        gain,
    output logic signed [SMP_W-1:0] out
);
    localparam int COEF_W = VOL_W + 2;
    localparam int PROD_W = SMP_W + COEF_W;
    localparam logic signed [PROD_W-1:0] MAXV =
        {{(PROD_W-SMP_W+1){1'b0}}, {(SMP_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] MINV =
        {{(PROD_W-SMP_W+1){1'b1}}, {(SMP_W-1){1'b0}}};

    logic [COEF_W-1:0]        coef;
    logic signed [PROD_W-1:0] smp_x;
    logic signed [PROD_W-1:0] coef_x;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [SMP_W-1:0]  sat;

    // Build the unsigned coefficient, mapping all ones to exact unity.
    always_comb begin
        coef   = {2'b00, gain} + {{(COEF_W-1){1'b0}}, gain[VOL_W-1]};
        smp_x  = {{(PROD_W-SMP_W){smp[SMP_W-1]}}, smp};
        coef_x = {{(PROD_W-COEF_W){1'b0}}, coef};
    end

    // Multiply, rescale and clamp to the sample range.
    always_comb begin
        prod    = smp_x * coef_x;
        shifted = prod >>> VOL_W;
        if (shifted > MAXV)      sat = MAXV[SMP_W-1:0];
        else if (shifted < MINV) sat = MINV[SMP_W-1:0];
        else                     sat = shifted[SMP_W-1:0];
    end

    // Register the scaled sample on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  out <= '0;
        else if (en) out <= sat;
    end
endmodule

// File: rtl/stereo_gain_ramp.sv
// Stereo clickless volume with soft mute. One ramp and one scaler per
// channel, both advanced by the shared sample strobe. Mute is the OR of
// the pin and the control bit and is sampled at each strobe.
// Assumes inputs are synchronous to clk.
module stereo_gain_ramp #(
    parameter int SMP_W  = gr_pkg::SMP_W_D,
    parameter int VOL_W  = gr_pkg::VOL_W_D,
    parameter int FINE_W = gr_pkg::FINE_W_D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_left,
    input  logic signed [SMP_W-1:0] smp_right,
    input  logic                    vol_load,
    input  logic [VOL_W-1:0]        vol_left,
    input  logic [VOL_W-1:0]        vol_right,
    input  logic                    mute_pin,
    input  logic                    mute_bit,
    output logic signed [SMP_W-1:0] out_left,
    output logic signed [SMP_W-1:0] out_right,
    output logic                    out_valid
);
    import gr_pkg::*;

    logic                    mute_any;
    logic signed [SMP_W-1:0] smp_a  [CH_N];
    logic signed [SMP_W-1:0] out_a  [CH_N];
    logic [VOL_W-1:0]        req_a  [CH_N];
    logic [VOL_W-1:0]        gain_w [CH_N];

    // Merge the two mute sources and fan inputs into channel arrays.
    always_comb begin
        mute_any      = mute_pin | mute_bit;
        smp_a[CH_LEFT]  = smp_left;
        smp_a[CH_RIGHT] = smp_right;
        req_a[CH_LEFT]  = vol_left;
        req_a[CH_RIGHT] = vol_right;
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        gr_ramp #(.VOL_W(VOL_W), .FINE_W(FINE_W)) u_ramp (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (smp_valid),
            .load_en (vol_load),
            .mute    (mute_any),
            .req_in  (req_a[c]),
            .gain    (gain_w[c])
        );

        gr_scale #(.SMP_W(SMP_W), .VOL_W(VOL_W)) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (smp_valid),
            .smp   (smp_a[c]),
            .gain  (gain_w[c]),
            .out   (out_a[c])
        );
    end

    assign out_left  = out_a[CH_LEFT];
    assign out_right = out_a[CH_RIGHT];

    // Flag the cycle in which fresh outputs are present.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= smp_valid;
    end
endmodule

// File: rtl/gr_chk.sv
// Assertion checker for stereo_gain_ramp, attached by bind.
// Observes ports and the two working volumes.
module gr_chk #(
    parameter int SMP_W  = gr_pkg::SMP_W_D,
    parameter int VOL_W  = gr_pkg::VOL_W_D,
    parameter int FINE_W = gr_pkg::FINE_W_D
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic                    mute_pin,
    input logic                    mute_bit,
    input logic signed [SMP_W-1:0] out_l,
    input logic signed [SMP_W-1:0] out_r,
    input logic                    out_valid,
    input logic [VOL_W-1:0]        gain_l,
    input logic [VOL_W-1:0]        gain_r
);
    int unsigned edges = 0;
    logic        rst_seen_n = 1'b1;

    // Track edges and the reset level seen at the last edge.
    always @(posedge clk) begin
        edges      <= edges + 1;
        rst_seen_n <= rst_n;
    end

    // R1
    always @(negedge clk) begin
        if (edges > 0 && !rst_seen_n)
            reset_mid_chk: assert (out_l == '0 && out_r == '0 && !out_valid);
    end

    // R4
    coarse_step_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (gain_l[VOL_W-1:FINE_W] == $past(gain_l[VOL_W-1:FINE_W]) ||
                       gain_l[VOL_W-1:FINE_W] == $past(gain_l[VOL_W-1:FINE_W]) + 1'b1 ||
                       gain_l[VOL_W-1:FINE_W] == $past(gain_l[VOL_W-1:FINE_W]) - 1'b1));

    // R4
    coarse_step_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (gain_r[VOL_W-1:FINE_W] == $past(gain_r[VOL_W-1:FINE_W]) ||
                       gain_r[VOL_W-1:FINE_W] == $past(gain_r[VOL_W-1:FINE_W]) + 1'b1 ||
                       gain_r[VOL_W-1:FINE_W] == $past(gain_r[VOL_W-1:FINE_W]) - 1'b1));

    // R7
    mute_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mute_pin || mute_bit) && smp_valid) |=>
            (gain_l[FINE_W-1:0] == '0 && gain_r[FINE_W-1:0] == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(gain_l) && $stable(gain_r) &&
                        $stable(out_l) && $stable(out_r)));

    // R12
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);

    // R12
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);
endmodule

bind stereo_gain_ramp gr_chk #(.SMP_W(SMP_W), .VOL_W(VOL_W), .FINE_W(FINE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .mute_pin  (mute_pin),
    .mute_bit  (mute_bit),
    .out_l     (out_left),
    .out_r     (out_right),
    .out_valid (out_valid),
    .gain_l    (gain_w[0]),
    .gain_r    (gain_w[1])
);

// File: tb/stereo_gain_ramp_test.sv
// Directed bench for stereo_gain_ramp; one task per scenario.
module stereo_gain_ramp_test;
    localparam logic signed [23:0] PROBE = 24'sd16384;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [23:0] smp_left = '0, smp_right = '0;
    logic vol_load = 1'b0;
    logic [13:0] vol_left = '0, vol_right = '0;
    logic mute_pin = 1'b0, mute_bit = 1'b0;
    logic signed [23:0] out_left, out_right;
    logic out_valid;

    int tests = 0;
    int fails = 0;
    logic [13:0] mg [2];
    logic [13:0] mr [2];

    always #4 clk = ~clk;

    stereo_gain_ramp uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right),
        .vol_load(vol_load), .vol_left(vol_left), .vol_right(vol_right),
        .mute_pin(mute_pin), .mute_bit(mute_bit),
        .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Gain update from R4/R5/R7: coarse steps by one, fine loads goal.
    function automatic logic [13:0] mstep(input logic [13:0] g, input logic [13:0] r, input bit m);
        logic [13:0] goal;
        logic [9:0]  hi;
        goal = m ? 14'd0 : r;
        hi   = g[13:4];
        if (hi < goal[13:4])      hi = hi + 10'd1;
        else if (hi > goal[13:4]) hi = hi - 10'd1;
        return {hi, goal[3:0]};
    endfunction

    // Output value from R3.
    function automatic logic signed [23:0] mscale(input logic signed [23:0] x, input logic [13:0] g);
        longint xs, c, p;
        xs = x;
        c  = longint'(g) + longint'(g[13]);
        p  = (xs * c) >>> 14;
        return p[23:0];
    endfunction

    task automatic strobe(input logic signed [23:0] xl, input logic signed [23:0] xr,
                          input bit ld, input logic [13:0] nl, input logic [13:0] nr,
                          input string tag);
        logic signed [23:0] el, er;
        bit m;
        @(negedge clk);
        smp_valid = 1'b1; smp_left = xl; smp_right = xr;
        if (ld) begin vol_load = 1'b1; vol_left = nl; vol_right = nr; end
        el = mscale(xl, mg[0]);
        er = mscale(xr, mg[1]);
        m  = mute_pin | mute_bit;
        mg[0] = mstep(mg[0], mr[0], m);
        mg[1] = mstep(mg[1], mr[1], m);
        if (ld) begin mr[0] = nl; mr[1] = nr; end
        @(negedge clk);
        smp_valid = 1'b0; vol_load = 1'b0;
        check(out_left == el, {tag, " left"}, out_left, el);
        check(out_right == er, {tag, " right"}, out_right, er);
        check(out_valid == 1'b1, {tag, " R12 valid"}, out_valid, 1);
    endtask

    task automatic load(input logic [13:0] nl, input logic [13:0] nr);
        @(negedge clk);
        vol_load = 1'b1; vol_left = nl; vol_right = nr;
        @(negedge clk);
        vol_load = 1'b0;
        mr[0] = nl; mr[1] = nr;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(negedge clk);
        smp_valid = 1'b1; smp_left = 24'sd5000; smp_right = -24'sd7000;
        vol_load = 1'b1; vol_left = 14'h3FFF; vol_right = 14'h3FFF;
        repeat (4) @(negedge clk);
        check(out_left == 0 && out_right == 0, "R1 outputs midscale in reset", out_left, 0);
        check(out_valid == 1'b0, "R1 out_valid low in reset", out_valid, 0);
        smp_valid = 1'b0; vol_load = 1'b0;
        mg[0] = '0; mg[1] = '0; mr[0] = '0; mr[1] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        // R2: gains are zero so a probe yields zero.
        strobe(PROBE, PROBE, 0, 0, 0, "R2 zero gain after reset");
    endtask

    task automatic t_fine;
        load(14'h0009, 14'h000C);
        strobe(PROBE, PROBE, 0, 0, 0, "R5 before fine load");
        strobe(PROBE, PROBE, 0, 0, 0, "R5 fine bits immediate");
        check(out_left == 9, "R5 left fine value", out_left, 9);
    endtask

    task automatic t_ramp;
        load(14'h3FFF, 14'h0105);
        for (int i = 0; i < 1030; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R4 R9 ramp up");
        check(out_right == 14'h0105, "R9 right settled", out_right, 14'h0105);
    endtask

    task automatic t_unity;
        strobe(24'sd8388607, -24'sd8388608, 0, 0, 0, "R11 R3 extremes");
        check(out_left == 24'sd8388607, "R11 max unchanged", out_left, 8388607);
        strobe(-24'sd8388608, 24'sd1234567, 0, 0, 0, "R11 R3 extremes");
        check(out_left == -24'sd8388608, "R11 min unchanged", out_left, -8388608);
        strobe(-24'sd1, 24'sd99, 0, 0, 0, "R3 small values");
    endtask

    task automatic t_hold;
        logic signed [23:0] hl, hr;
        hl = out_left; hr = out_right;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            smp_left = 24'(i * 777); smp_right = -24'(i * 31);
            check(out_left == hl && out_right == hr, "R10 hold without strobe", out_left, hl);
            check(out_valid == 1'b0, "R12 valid low when idle", out_valid, 0);
        end
    endtask

    task automatic t_latch;
        logic signed [23:0] hl;
        hl = out_left;
        load(14'h0000, 14'h3FFF);
        repeat (3) @(negedge clk);
        check(out_left == hl, "R6 load alone leaves output", out_left, hl);
        // Load together with a strobe: the strobe uses the held request.
        strobe(PROBE, PROBE, 1, 14'h3FFF, 14'h0000, "R6 load with strobe");
        strobe(PROBE, PROBE, 0, 0, 0, "R6 after coincident load");
        for (int i = 0; i < 5; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R6 R4 continue");
    endtask

    task automatic t_mute;
        load(14'h3FFF, 14'h3FFF);
        for (int i = 0; i < 1030; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R4 settle unity");
        @(negedge clk); mute_pin = 1'b1;
        for (int i = 0; i < 1030; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R7 ramp down by pin");
        strobe(24'sd8388607, -24'sd8388608, 0, 0, 0, "R7 muted silence");
        check(out_left == 0 && out_right == 0, "R7 zero at full scale", out_left, 0);
        @(negedge clk); mute_pin = 1'b0; mute_bit = 1'b1;
        strobe(PROBE, PROBE, 0, 0, 0, "R7 bit keeps mute");
        @(negedge clk); mute_bit = 1'b0;
        for (int i = 0; i < 40; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R8 ramp back");
        @(negedge clk); mute_bit = 1'b1;
        for (int i = 0; i < 10; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R7 mid-ramp mute");
        @(negedge clk); mute_bit = 1'b0;
        for (int i = 0; i < 1030; i++)
            strobe(PROBE, PROBE, 0, 0, 0, "R8 back to request");
        check(out_left == 16384, "R8 request restored", out_left, 16384);
    endtask

    initial begin
        t_reset;
        t_fine;
        t_ramp;
        t_unity;
        t_hold;
        t_latch;
        t_mute;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule